// File: doc/BRIEF.md
# Keypad Controller Command Processor

This block decodes commands and holds settings for a keypad and GPIO controller. It sits behind a byte-oriented serial target, such as an I2C slave engine, which is not part of this block. The engine signals the start of each transfer and hands over each received byte. It also asks for each byte it has to send. In a write transfer the first byte selects a command and the following bytes are its parameters. In a read transfer the returned bytes belong to the command selected last.

The block stores the settings for configuration, clock, scan active time, debounce, keypad size, and the 16-bit GPIO pull, direction and mask words. It checks every parameter and flags command codes it does not know. Errors are collected in a sticky error byte. Events are collected in a status byte, and an active-low interrupt stays asserted while any status bit is set. The key FIFO and the PWM engines sit outside the block and are linked to it by single-cycle strobes.

A command that has taken its last parameter is parked at code 0xFF. Any further parameter byte in the same transfer is then treated as a bad parameter.

Top module: `kcmd_engine`

## Requirements
- R1: `start_i` sets the byte counter to 0. In a write transfer, byte 0 loads the command register and byte n≥1 is parameter n-1. A read returns byte index equal to the counter. The counter steps after every byte and saturates at its maximum. Read data appears on `rd_data_o` the cycle after `rd_i`.
- R2: After the hardware reset the settings are: configuration 0x80, status 0x10, active time 125, debounce 3, key size 0x33, clock 0x08, error 0, all GPIO words 0, and the command register 0xFF.
- R3: Command 0x83 with parameter 0xAA restores configuration 0x80, status 0x10, active time 125, debounce 3, key size 0x33 and clock 0x08. The error byte and the GPIO words are left unchanged. Any other parameter sets the bad-parameter error. Either way the command parks.
- R4: Status bit 0 is keypad (`key_evt_i`), bit 3 is error, bit 4 is not-initialised, and bits 7:5 follow `pwm_end_i[2:0]`. `irq_n_o` is low exactly when the status byte is nonzero.
- R5: Reading 0x82 returns the status byte and then clears it. The clear does not happen while bit 4 is set.
- R6: Write-configuration 0x81 stores its parameter, clears the status byte, pulses `fifo_clr_o` for one cycle (the cycle after the byte) and parks.
- R7: Commands 0x84, 0x85 and 0x86 write the pull, direction and mask words. The first parameter sets the word to {0x00, byte}. The second parameter ORs in the high byte and parks the command. Reading 0x87 returns the direction word and reading 0x88 returns the mask word.
- R8: Key size (0x90) needs each nibble to be at least 3, the low nibble at most 12 and the high nibble at most 8. Debounce (0x8F) needs a nonzero value. The two low bits of the clock byte (0x93) must be 00 or 11. A violation sets bad-parameter, but the value is still stored. Active time is written with 0x8B. All of these commands park.
- R9: The readable values are: 0x80 gives 0x0400, 0x8C gives the error byte, 0x91 gives the key size, 0x92 gives the low four configuration bits, and 0x94 gives (clock & 0xFC) | 2. Byte index 0 returns bits 7:0 and index 1 returns bits 15:8. Any higher index returns 0.
- R10: Error bit 1 (unknown command) is set by a parameter byte to a code that is not a write command. It is also set by a read of a code that is not a read command, and such a read returns 0. Error bit 0 (bad parameter) is set by a parameter byte while the command register holds 0xFF. Every error also sets status bit 3. Error bits clear only on the hardware reset.
- R11: `fifo_ovf_i` sets error bit 6 and status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer start, either direction |
| wr_i | input | 1 | Received byte strobe |
| rd_i | input | 1 | Byte request strobe |
| data_i | input | 8 | Received byte |
| rd_data_o | output | 8 | Byte to send, valid the cycle after `rd_i` |
| irq_n_o | output | 1 | Active-low interrupt |
| key_evt_i | input | 1 | Key event pushed to the FIFO |
| pwm_end_i | input | 3 | PWM engine finished, one bit per engine |
| fifo_ovf_i | input | 1 | Key FIFO overflowed |
| fifo_clr_o | output | 1 | Key FIFO clear request |
| cfg_o | output | 8 | Configuration byte |
| clk_o | output | 8 | Clock setting byte |
| ksz_o | output | 8 | Keypad size byte |
| act_o | output | 8 | Scan active time |
| deb_o | output | 8 | Debounce time |
| pull_o | output | 16 | GPIO pull select |
| dir_o | output | 16 | GPIO direction |
| mask_o | output | 16 | GPIO mask/state |

## Verification
Every register update, error flag and status change happens at the clock edge that samples the strobe, so `irq_n_o`, `fifo_clr_o` and the setting outputs are due one cycle after a byte or event. `rd_data_o` is also registered, so its value is due one cycle after `rd_i`. The bench drives each strobe on a falling edge and drops it on the next falling edge. It then compares on that second falling edge, after exactly one rising edge. A reference model in the bench steps with each byte, and a seeded random mix of commands runs after the directed corner cases.

// File: rtl/kce_pkg.sv
package kce_pkg;
  localparam logic [7:0] OP_RD_ID   = 8'h80;
  localparam logic [7:0] OP_WR_CFG  = 8'h81;
  localparam logic [7:0] OP_RD_STAT = 8'h82;
  localparam logic [7:0] OP_RESET   = 8'h83;
  localparam logic [7:0] OP_WR_PULL = 8'h84;
  localparam logic [7:0] OP_WR_DIR  = 8'h85;
  localparam logic [7:0] OP_WR_MASK = 8'h86;
  localparam logic [7:0] OP_RD_DIR  = 8'h87;
  localparam logic [7:0] OP_RD_MASK = 8'h88;
  localparam logic [7:0] OP_WR_ACT  = 8'h8B;
  localparam logic [7:0] OP_RD_ERR  = 8'h8C;
  localparam logic [7:0] OP_WR_DEB  = 8'h8F;
  localparam logic [7:0] OP_WR_KSZ  = 8'h90;
  localparam logic [7:0] OP_RD_KSZ  = 8'h91;
  localparam logic [7:0] OP_RD_CFG  = 8'h92;
  localparam logic [7:0] OP_WR_CLK  = 8'h93;
  localparam logic [7:0] OP_RD_CLK  = 8'h94;
  localparam logic [7:0] OP_PARKED  = 8'hFF;

  localparam logic [7:0] RESET_KEY  = 8'hAA;
  localparam logic [15:0] CHIP_ID   = 16'h0400;

  localparam int ST_KEY    = 0;
  localparam int ST_ERR    = 3;
  localparam int ST_NOINIT = 4;
  localparam int ST_PWM_LO = 5;
  localparam int NUM_PWM   = 3;

  localparam int ER_BADPAR = 0;
  localparam int ER_UNKCMD = 1;
  localparam int ER_FIFOOV = 6;

  localparam int GPIO_W    = 16;

  localparam logic [7:0] DEF_CFG  = 8'h80;
  localparam logic [7:0] DEF_STAT = 8'h10;
  localparam logic [7:0] DEF_ACT  = 8'd125;
  localparam logic [7:0] DEF_DEB  = 8'd3;
  localparam logic [7:0] DEF_KSZ  = 8'h33;
  localparam logic [7:0] DEF_CLK  = 8'h08;

  localparam logic [3:0] KSZ_MIN     = 4'd3;
  localparam logic [3:0] KSZ_LO_MAX  = 4'd12;
  localparam logic [3:0] KSZ_HI_MAX  = 4'd8;
endpackage

// File: rtl/kce_seq.sv
module kce_seq
  import kce_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       data_i,
  input  logic             park_i,
  output logic [7:0]       cmd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             prm_wr_o,
  output logic             prm_first_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [7:0]       cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign prm_wr_o    = wr_i && !start_i && (cnt_q != '0);
  assign prm_first_o = (cnt_q == CNT_ONE);

  always_comb begin
    cnt_d = cnt_q;
    cmd_d = cmd_q;
    if (start_i) begin
      cnt_d = '0;
    end else if (wr_i || rd_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
      if (wr_i && (cnt_q == '0)) cmd_d = data_i;
      else if (park_i)           cmd_d = OP_PARKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= OP_PARKED;
      cnt_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      cnt_q <= cnt_d;
    end
  end

  assign cmd_o = cmd_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/kce_regs.sv
module kce_regs
  import kce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prm_wr_i,
  input  logic              prm_first_i,
  input  logic              rd_i,
  input  logic              rd_known_i,
  input  logic [7:0]        cmd_i,
  input  logic [7:0]        data_i,
  input  logic              key_evt_i,
  input  logic [NUM_PWM-1:0] pwm_end_i,
  input  logic              fifo_ovf_i,
  output logic              park_o,
  output logic              fifo_clr_o,
  output logic [7:0]        stat_o,
  output logic [7:0]        err_o,
  output logic [7:0]        cfg_o,
  output logic [7:0]        act_o,
  output logic [7:0]        deb_o,
  output logic [7:0]        ksz_o,
  output logic [7:0]        clk_o,
  output logic [GPIO_W-1:0] pull_o,
  output logic [GPIO_W-1:0] dir_o,
  output logic [GPIO_W-1:0] mask_o
);
  logic [7:0] stat_q, stat_d, err_q, err_d;
  logic [7:0] cfg_q, cfg_d, act_q, act_d, deb_q, deb_d;
  logic [7:0] ksz_q, ksz_d, clk_q, clk_d;
  logic [GPIO_W-1:0] pull_q, pull_d, dir_q, dir_d, mask_q, mask_d;
  logic clr_q, clr_d;
  logic bad, unk, st_clr, st_init, park;
  logic [7:0] st_base;

  function automatic logic ksz_bad(input logic [7:0] v);
    return (v[3:0] < KSZ_MIN) || (v[3:0] > KSZ_LO_MAX) ||
           (v[7:4] < KSZ_MIN) || (v[7:4] > KSZ_HI_MAX);
  endfunction

  function automatic logic [GPIO_W-1:0] gpio_next(input logic [GPIO_W-1:0] cur,
                                                  input logic first,
                                                  input logic [7:0] v);
    return first ? GPIO_W'(v) : (cur | {v, 8'h00});
  endfunction

  always_comb begin
    cfg_d = cfg_q;  act_d = act_q;  deb_d = deb_q;
    ksz_d = ksz_q;  clk_d = clk_q;
    pull_d = pull_q; dir_d = dir_q; mask_d = mask_q;
    bad = 1'b0; unk = 1'b0; st_clr = 1'b0; st_init = 1'b0;
    park = 1'b0; clr_d = 1'b0;
    if (prm_wr_i) begin
      case (cmd_i)
        OP_WR_CFG: begin
          cfg_d = data_i; st_clr = 1'b1; clr_d = 1'b1; park = 1'b1;
        end
        OP_RESET: begin
          park = 1'b1;
          if (data_i == RESET_KEY) begin
            cfg_d = DEF_CFG; act_d = DEF_ACT; deb_d = DEF_DEB;
            ksz_d = DEF_KSZ; clk_d = DEF_CLK; st_init = 1'b1;
          end else begin
            bad = 1'b1;
          end
        end
        OP_WR_PULL: begin
          pull_d = gpio_next(pull_q, prm_first_i, data_i); park = !prm_first_i;
        end
        OP_WR_DIR: begin
          dir_d = gpio_next(dir_q, prm_first_i, data_i); park = !prm_first_i;
        end
        OP_WR_MASK: begin
          mask_d = gpio_next(mask_q, prm_first_i, data_i); park = !prm_first_i;
        end
        OP_WR_ACT: begin
          act_d = data_i; park = 1'b1;
        end
        OP_WR_DEB: begin
          deb_d = data_i; park = 1'b1; bad = (data_i == 8'h00);
        end
        OP_WR_KSZ: begin
          ksz_d = data_i; park = 1'b1; bad = ksz_bad(data_i);
        end
        OP_WR_CLK: begin
          clk_d = data_i; park = 1'b1; bad = (data_i[1] != data_i[0]);
        end
        OP_PARKED: bad = 1'b1;
        default:   unk = 1'b1;
      endcase
    end
    if (rd_i) begin
      if (!rd_known_i) unk = 1'b1;
      else if ((cmd_i == OP_RD_STAT) && !stat_q[ST_NOINIT]) st_clr = 1'b1;
    end

    err_d = err_q;
    err_d[ER_BADPAR] = err_q[ER_BADPAR] | bad;
    err_d[ER_UNKCMD] = err_q[ER_UNKCMD] | unk;
    err_d[ER_FIFOOV] = err_q[ER_FIFOOV] | fifo_ovf_i;

    if (st_init)     st_base = DEF_STAT;
    else if (st_clr) st_base = 8'h00;
    else             st_base = stat_q;
    stat_d = st_base;
    stat_d[ST_KEY] = st_base[ST_KEY] | key_evt_i;
    stat_d[ST_ERR] = st_base[ST_ERR] | bad | unk | fifo_ovf_i;
    stat_d[ST_PWM_LO +: NUM_PWM] = st_base[ST_PWM_LO +: NUM_PWM] | pwm_end_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= DEF_STAT; err_q <= '0;
      cfg_q <= DEF_CFG; act_q <= DEF_ACT; deb_q <= DEF_DEB;
      ksz_q <= DEF_KSZ; clk_q <= DEF_CLK;
      pull_q <= '0; dir_q <= '0; mask_q <= '0;
      clr_q <= 1'b0;
    end else begin
      stat_q <= stat_d; err_q <= err_d; clr_q <= clr_d;
      if (prm_wr_i) begin
        cfg_q <= cfg_d; act_q <= act_d; deb_q <= deb_d;
        ksz_q <= ksz_d; clk_q <= clk_d;
        pull_q <= pull_d; dir_q <= dir_d; mask_q <= mask_d;
      end
    end
  end

  assign park_o = park;
  assign fifo_clr_o = clr_q;
  assign stat_o = stat_q; assign err_o = err_q;
  assign cfg_o = cfg_q; assign act_o = act_q; assign deb_o = deb_q;
  assign ksz_o = ksz_q; assign clk_o = clk_q;
  assign pull_o = pull_q; assign dir_o = dir_q; assign mask_o = mask_q;
endmodule

// File: rtl/kce_rdmux.sv
module kce_rdmux
  import kce_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [7:0]        cmd_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [7:0]        stat_i,
  input  logic [7:0]        err_i,
  input  logic [3:0]        cfg_lo_i,
  input  logic [7:0]        ksz_i,
  input  logic [5:0]        clk_hi_i,
  input  logic [GPIO_W-1:0] dir_i,
  input  logic [GPIO_W-1:0] mask_i,
  output logic              known_o,
  output logic [7:0]        byte_o
);
  logic [15:0] word;

  always_comb begin
    known_o = 1'b1;
    case (cmd_i)
      OP_RD_ID:   word = CHIP_ID;
      OP_RD_STAT: word = {8'h00, stat_i};
      OP_RD_DIR:  word = dir_i;
      OP_RD_MASK: word = mask_i;
      OP_RD_ERR:  word = {8'h00, err_i};
      OP_RD_KSZ:  word = {8'h00, ksz_i};
      OP_RD_CFG:  word = {12'h000, cfg_lo_i};
      OP_RD_CLK:  word = {8'h00, clk_hi_i, 2'b10};
      default: begin
        word = 16'h0000;
        known_o = 1'b0;
      end
    endcase
    if (idx_i == '0)                 byte_o = word[7:0];
    else if (idx_i == CNT_W'(1))     byte_o = word[15:8];
    else                             byte_o = 8'h00;
  end
endmodule

// File: rtl/kcmd_engine.sv
module kcmd_engine
  import kce_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  data_i,
  output logic [7:0]  rd_data_o,
  output logic        irq_n_o,
  input  logic        key_evt_i,
  input  logic [2:0]  pwm_end_i,
  input  logic        fifo_ovf_i,
  output logic        fifo_clr_o,
  output logic [7:0]  cfg_o,
  output logic [7:0]  clk_o,
  output logic [7:0]  ksz_o,
  output logic [7:0]  act_o,
  output logic [7:0]  deb_o,
  output logic [15:0] pull_o,
  output logic [15:0] dir_o,
  output logic [15:0] mask_o
);
  logic [7:0]       cmd_w, stat_w, err_w, rd_byte, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_w;
  logic             park_w, prm_wr_w, prm_first_w, known_w;

  kce_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i), .rd_i(rd_i),
    .data_i(data_i), .park_i(park_w), .cmd_o(cmd_w), .cnt_o(cnt_w),
    .prm_wr_o(prm_wr_w), .prm_first_o(prm_first_w)
  );

  kce_regs u_regs (
    .clk(clk), .rst_n(rst_n), .prm_wr_i(prm_wr_w), .prm_first_i(prm_first_w),
    .rd_i(rd_i), .rd_known_i(known_w), .cmd_i(cmd_w), .data_i(data_i),
    .key_evt_i(key_evt_i), .pwm_end_i(pwm_end_i), .fifo_ovf_i(fifo_ovf_i),
    .park_o(park_w), .fifo_clr_o(fifo_clr_o), .stat_o(stat_w), .err_o(err_w),
    .cfg_o(cfg_o), .act_o(act_o), .deb_o(deb_o), .ksz_o(ksz_o), .clk_o(clk_o),
    .pull_o(pull_o), .dir_o(dir_o), .mask_o(mask_o)
  );

  kce_rdmux #(.CNT_W(CNT_W)) u_rdmux (
    .cmd_i(cmd_w), .idx_i(cnt_w), .stat_i(stat_w), .err_i(err_w),
    .cfg_lo_i(cfg_o[3:0]), .ksz_i(ksz_o), .clk_hi_i(clk_o[7:2]),
    .dir_i(dir_o), .mask_i(mask_o), .known_o(known_w), .byte_o(rd_byte)
  );

  always_comb rd_d = rd_i ? rd_byte : rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 8'h00;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
  assign irq_n_o   = (stat_w == 8'h00);
endmodule

// File: rtl/kce_chk.sv
module kce_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [7:0]       data_i,
  input logic             key_evt_i,
  input logic             irq_n_o,
  input logic [7:0]       rd_data_o,
  input logic [7:0]       cmd_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [7:0]       stat_q,
  input logic [7:0]       err_q
);
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0)); // R1
  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !start_i && (cnt_q == '0)) |=> (cmd_q == $past(data_i))); // R1
  AST_PARKED_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !start_i && (cnt_q != '0) && (cmd_q == 8'hFF))
      |=> ((cmd_q == 8'hFF) && err_q[0] && stat_q[3])); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(err_q)) == $past(err_q))); // R10
  AST_KEY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    key_evt_i |=> !irq_n_o); // R4
  AST_NOINIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && (cmd_q == 8'h82) && stat_q[4]) |=> stat_q[4]); // R5
  AST_CFG_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (cmd_q == 8'h92)) |=> (rd_data_o[7:4] == 4'h0)); // R9
  AST_CLK_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !start_i && (cmd_q == 8'h94) && (cnt_q == '0))
      |=> (rd_data_o[1:0] == 2'b10)); // R9
endmodule

bind kcmd_engine kce_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i), .rd_i(rd_i),
  .data_i(data_i), .key_evt_i(key_evt_i), .irq_n_o(irq_n_o),
  .rd_data_o(rd_data_o), .cmd_q(cmd_w), .cnt_q(cnt_w), .stat_q(stat_w),
  .err_q(err_w)
);

// File: tb/tb_kcmd_engine.sv
`timescale 1ns/1ps
module tb_kcmd_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic key_evt_i = 1'b0, fifo_ovf_i = 1'b0;
  logic [2:0] pwm_end_i = 3'b000;
  logic [7:0] rd_data_o, cfg_o, clk_o, ksz_o, act_o, deb_o;
  logic irq_n_o, fifo_clr_o;
  logic [15:0] pull_o, dir_o, mask_o;

  always #2 clk = ~clk;

  kcmd_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i), .rd_i(rd_i),
    .data_i(data_i), .rd_data_o(rd_data_o), .irq_n_o(irq_n_o),
    .key_evt_i(key_evt_i), .pwm_end_i(pwm_end_i), .fifo_ovf_i(fifo_ovf_i),
    .fifo_clr_o(fifo_clr_o), .cfg_o(cfg_o), .clk_o(clk_o), .ksz_o(ksz_o),
    .act_o(act_o), .deb_o(deb_o), .pull_o(pull_o), .dir_o(dir_o), .mask_o(mask_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_cmd, m_cfg, m_st, m_er, m_act, m_deb, m_ksz, m_clk;
  logic [15:0] m_pull, m_dir, m_mask;
  int m_cnt;
  bit m_clr;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_hard_reset();
    m_cmd = 8'hFF; m_cfg = 8'h80; m_st = 8'h10; m_er = 8'h00; m_act = 8'd125;
    m_deb = 8'd3; m_ksz = 8'h33; m_clk = 8'h08; m_pull = 0; m_dir = 0; m_mask = 0;
    m_cnt = 0; m_clr = 0;
  endtask

  task automatic m_err(input int b);
    m_er[b] = 1'b1; m_st[3] = 1'b1;
  endtask

  task automatic m_wr(input logic [7:0] v);
    m_clr = 0;
    if (m_cnt == 0) m_cmd = v;
    else begin
      case (m_cmd)
        8'h81: begin m_cfg = v; m_st = 0; m_clr = 1; m_cmd = 8'hFF; end
        8'h83: begin
          if (v == 8'hAA) begin
            m_cfg = 8'h80; m_st = 8'h10; m_act = 8'd125; m_deb = 8'd3;
            m_ksz = 8'h33; m_clk = 8'h08;
          end else m_err(0);
          m_cmd = 8'hFF;
        end
        8'h84: if (m_cnt == 1) m_pull = {8'h00, v}; else begin m_pull[15:8] |= v; m_cmd = 8'hFF; end
        8'h85: if (m_cnt == 1) m_dir = {8'h00, v};  else begin m_dir[15:8] |= v;  m_cmd = 8'hFF; end
        8'h86: if (m_cnt == 1) m_mask = {8'h00, v}; else begin m_mask[15:8] |= v; m_cmd = 8'hFF; end
        8'h8B: begin m_act = v; m_cmd = 8'hFF; end
        8'h8F: begin m_deb = v; m_cmd = 8'hFF; if (v == 0) m_err(0); end
        8'h90: begin
          m_ksz = v; m_cmd = 8'hFF;
          if (v[3:0] < 3 || v[3:0] > 12 || v[7:4] < 3 || v[7:4] > 8) m_err(0);
        end
        8'h93: begin m_clk = v; m_cmd = 8'hFF; if (v[1] != v[0]) m_err(0); end
        8'hFF: m_err(0);
        default: m_err(1);
      endcase
    end
    if (m_cnt < 15) m_cnt++;
  endtask

  task automatic m_rd(output logic [7:0] e);
    logic [15:0] w;
    bit ok;
    ok = 1;
    case (m_cmd)
      8'h80: w = 16'h0400;
      8'h82: w = {8'h00, m_st};
      8'h87: w = m_dir;
      8'h88: w = m_mask;
      8'h8C: w = {8'h00, m_er};
      8'h91: w = {8'h00, m_ksz};
      8'h92: w = {12'h000, m_cfg[3:0]};
      8'h94: w = {8'h00, m_clk[7:2], 2'b10};
      default: begin w = 16'h0000; ok = 0; end
    endcase
    e = (m_cnt == 0) ? w[7:0] : (m_cnt == 1) ? w[15:8] : 8'h00;
    if (!ok) m_err(1);
    else if (m_cmd == 8'h82 && !m_st[4]) m_st = 0;
    if (m_cnt < 15) m_cnt++;
  endtask

  task automatic chk_outs();
    chk("R4 irq_n", {15'h0, irq_n_o}, {15'h0, (m_st == 8'h00)});
    chk("R6 fifo_clr", {15'h0, fifo_clr_o}, {15'h0, m_clr});
    chk("R7 pull", pull_o, m_pull);
    chk("R7 dir", dir_o, m_dir);
    chk("R7 mask", mask_o, m_mask);
    chk("R8 act", {8'h0, act_o}, {8'h0, m_act});
    chk("R8 deb", {8'h0, deb_o}, {8'h0, m_deb});
    chk("R8 ksz", {8'h0, ksz_o}, {8'h0, m_ksz});
    chk("R8 clk", {8'h0, clk_o}, {8'h0, m_clk});
    chk("R3 cfg", {8'h0, cfg_o}, {8'h0, m_cfg});
  endtask

  task automatic t_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    m_cnt = 0; m_clr = 0;
  endtask

  task automatic t_wr(input logic [7:0] v);
    @(negedge clk); wr_i = 1'b1; data_i = v;
    @(negedge clk); wr_i = 1'b0;
    m_wr(v);
    chk_outs();
  endtask

  task automatic t_rd(input string tag);
    logic [7:0] e;
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    m_rd(e);
    chk(tag, {8'h0, rd_data_o}, {8'h0, e});
    chk("R4 irq_n after read", {15'h0, irq_n_o}, {15'h0, (m_st == 8'h00)});
    m_clr = 0;
  endtask

  task automatic t_sel_read(input logic [7:0] c, input int n, input string tag);
    t_start(); t_wr(c); t_start();
    for (int i = 0; i < n; i++) t_rd(tag);
  endtask

  task automatic t_events(input logic k, input logic [2:0] p, input logic f);
    @(negedge clk); key_evt_i = k; pwm_end_i = p; fifo_ovf_i = f;
    @(negedge clk); key_evt_i = 1'b0; pwm_end_i = 3'b000; fifo_ovf_i = 1'b0;
    if (k) m_st[0] = 1'b1;
    m_st[7:5] |= p;
    if (f) m_err(6);
    m_clr = 0;
    chk("R4 R11 irq_n after event", {15'h0, irq_n_o}, {15'h0, (m_st == 8'h00)});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_hard_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk_outs();
    chk("R2 irq_n low at reset", {15'h0, irq_n_o}, 16'h0000);
    t_sel_read(8'h92, 1, "R9 R2 cfg read");
    t_sel_read(8'h94, 1, "R9 R2 clock read");
    t_sel_read(8'h80, 3, "R9 R1 id bytes");
    t_sel_read(8'h91, 2, "R9 ksz read");
    t_sel_read(8'h8C, 1, "R2 error zero");
    // R5: not-initialised blocks clear
    t_sel_read(8'h82, 2, "R5 status noinit held");
    // R6: config write
    t_start(); t_wr(8'h81); t_wr(8'h05);
    t_wr(8'h77);                              // R10 parked extra byte
    t_sel_read(8'h82, 2, "R5 status read then clear");
    // R7: GPIO 16-bit
    t_start(); t_wr(8'h85); t_wr(8'h34); t_wr(8'h12); t_wr(8'h00);
    t_sel_read(8'h87, 3, "R7 dir read");
    t_start(); t_wr(8'h86); t_wr(8'hC3); t_wr(8'h5A);
    t_sel_read(8'h88, 2, "R7 mask read");
    t_start(); t_wr(8'h84); t_wr(8'h0F); t_wr(8'hF0);
    // R10: unknown commands both directions
    t_start(); t_wr(8'h8D); t_wr(8'h01);
    t_sel_read(8'h81, 1, "R10 read of write command");
    t_sel_read(8'h8C, 1, "R10 error byte");
    // R8: parameter checks
    t_start(); t_wr(8'h90); t_wr(8'h23);
    t_start(); t_wr(8'h90); t_wr(8'h3D);
    t_start(); t_wr(8'h90); t_wr(8'h93);
    t_start(); t_wr(8'h90); t_wr(8'h8C);
    t_start(); t_wr(8'h8F); t_wr(8'h00);
    t_start(); t_wr(8'h93); t_wr(8'h01);
    t_start(); t_wr(8'h93); t_wr(8'hF3);
    t_start(); t_wr(8'h8B); t_wr(8'h40);
    t_sel_read(8'h94, 1, "R8 R9 clock format");
    // R3: reset command
    t_start(); t_wr(8'h83); t_wr(8'h55);
    t_start(); t_wr(8'h83); t_wr(8'hAA);
    t_sel_read(8'h82, 1, "R3 status after reset cmd");
    t_sel_read(8'h8C, 1, "R3 error kept");
    // R4, R11: events
    t_start(); t_wr(8'h81); t_wr(8'h00);
    t_events(1'b1, 3'b000, 1'b0);
    t_events(1'b0, 3'b010, 1'b0);
    t_events(1'b0, 3'b000, 1'b1);
    t_sel_read(8'h82, 2, "R4 R11 status bits");
    t_sel_read(8'h8C, 1, "R11 fifo overflow error");
    // R1: counter saturation on a long read
    t_sel_read(8'h80, 18, "R1 long read");

    // random phase
    void'($urandom(32'd1234));
    for (int it = 0; it < 600; it++) begin
      logic [7:0] c;
      int sel;
      sel = int'($urandom % 24);
      case (sel)
        0: c = 8'h80;  1: c = 8'h81;  2: c = 8'h82;  3: c = 8'h83;
        4: c = 8'h84;  5: c = 8'h85;  6: c = 8'h86;  7: c = 8'h87;
        8: c = 8'h88;  9: c = 8'h8B; 10: c = 8'h8C; 11: c = 8'h8F;
        12: c = 8'h90; 13: c = 8'h91; 14: c = 8'h92; 15: c = 8'h93;
        16: c = 8'h94; 17: c = 8'hFF; 18: c = 8'h83;
        default: c = 8'($urandom);
      endcase
      if ($urandom % 4 == 0) begin
        t_events(1'($urandom), 3'($urandom), ($urandom % 8) == 0);
      end else if ($urandom % 2 == 0) begin
        t_sel_read(c, 1 + int'($urandom % 3), "R9 R10 random read");
      end else begin
        t_start(); t_wr(c);
        for (int j = 0; j < int'($urandom % 4); j++) begin
          if (c == 8'h83 && ($urandom % 2 == 0)) t_wr(8'hAA);
          else t_wr(8'($urandom));
        end
      end
    end
    t_sel_read(8'h8C, 1, "R10 final error byte");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule